// File: doc/BRIEF.md
# Synchronizing I2C Serial Clock Generator

This block produces the serial clock of an I2C master on a clock line that is shared, wired-AND fashion, with other masters and with slaves that stretch the clock. It never drives the line high. It only asserts a drive-low enable for an open-drain pad, and it watches the real line level through a synchronizer and a glitch filter. Each phase is timed from what the line actually does, so the resulting bus clock has the low time of the slowest participant and the high time of the fastest.

The controller sets a low-period count and a high-period count, both in system clock cycles, and raises `enable`. The counts are captured once, when the block leaves idle. `stopReq` or a low `enable` releases the line at once and returns the block to idle. Two single-cycle strobes tell the byte logic when data may be changed (early in the low phase) and when it may be sampled (early in the high phase).

The filtered view of the line lags the pad by a fixed latency, LAT = SYNC_STAGES + GLITCH_CYCLES + 1 cycles. LAT is 6 with the default parameters. Every phase the block times itself therefore lasts its programmed count plus LAT.

Top module: `sclGen`

## Requirements
- R1: After reset, and in the cycle after any cycle in which `enable` is low, `sclDriveLow`, `sampleStb` and `changeStb` are all 0.
- R2: When `enable` is high with `stopReq` low in idle, `sclDriveLow` is 1 in the next cycle.
- R3: With no other device on the line, the line low time is max(lowCount,1) + LAT cycles.
- R4: With no other device on the line, the line high time is max(highCount,1) + LAT cycles.
- R5: After its own low count ends, the block keeps the line released while another device holds it low, and it starts timing the high phase only once the line reads high.
- R6: A falling edge on the line during the high phase, from any device, ends the high phase at once and starts a fresh low count. The combined high time is therefore the shorter of the participants' high times.
- R7: The low count restarts on the line's falling edge, so the combined low time is the longer of the participants' low times.
- R8: A programmed count of 0 behaves as a count of 1.
- R9: `lowCount` and `highCount` are captured when the block leaves idle. Changing them while running has no effect on the periods.
- R10: `stopReq` high makes `sclDriveLow` 0 in the next cycle and sends the block to idle. Dropping `stopReq` with `enable` still high starts a new low phase in the following cycle.
- R11: `changeStb` is a one-cycle pulse in the first cycle of the low count (LAT+1 cycles after `sclDriveLow` rises, line held low). `sampleStb` is a one-cycle pulse in the first cycle of the high count (LAT+1 cycles after the line is released). The two never coincide.
- R12: A low pulse on the line shorter than GLITCH_CYCLES cycles during the high phase is ignored, so the high phase keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low forces idle |
| stopReq | input | 1 | Stop request; high forces idle |
| lowCount | input | CNT_W | Low-phase count in cycles, captured at start |
| highCount | input | CNT_W | High-phase count in cycles, captured at start |
| sclIn | input | 1 | Sampled level of the shared clock line |
| sclDriveLow | output | 1 | Open-drain enable: 1 pulls the line low |
| sampleStb | output | 1 | One-cycle pulse at the start of the high count |
| changeStb | output | 1 | One-cycle pulse at the start of the low count |

## Verification
The bound checker watches, on every cycle, the port-level rules that need no knowledge of the other devices. These are: the release after a disable or a stop, the drive-low in the cycle after start, and the strobe rules (each strobe is one cycle long, the sample strobe only appears with the line released, the change strobe only with the line driven, and the two never coincide). The phase lengths depend on how the block interacts with another clock source on the wired-AND line, so only the bench scenarios can show them. These cover the combined low and high times with a slower and a faster partner, the high wait-state, zero counts, counts changed in mid-run, and a short glitch that must not cut the high phase.

// File: rtl/sclGenPkg.sv
package sclGenPkg;
  // commands from the control FSM to the datapath
  typedef struct packed {
    logic clear;     // clear the period counter
    logic latchCfg;  // capture the programmed counts
    logic loadLow;   // start a low-period count
    logic loadHigh;  // start a high-period count
  } sclCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HWAIT = 2'd2,
    ST_HIGH  = 2'd3
  } sclStateT;
endpackage

// File: rtl/sclGenDatapath.sv
module sclGenDatapath
  import sclGenPkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclCtrlT          ctrl,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             sclIn,
  output logic             lineHigh,
  output logic             lineFell,
  output logic             cntDone,
  output logic             cntIdle
);
  localparam int FW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [FW-1:0]    FLT_LAST = FW'(GLITCH_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   filtQ, filtPrevQ;
  logic [FW-1:0]          fltCnt;
  logic [CNT_W-1:0]       lowCfg, highCfg, perCnt;
  logic                   syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];

  // synchronizer chain; idle bus reads high
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= sclIn;
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
    end
  endgenerate

  // R12: a level must persist GLITCH_CYCLES cycles before it is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtQ     <= 1'b1;
      filtPrevQ <= 1'b1;
      fltCnt    <= '0;
    end else begin
      filtPrevQ <= filtQ;
      if (syncOut == filtQ) begin
        fltCnt <= '0;
      end else if (fltCnt == FLT_LAST) begin
        filtQ  <= syncOut;
        fltCnt <= '0;
      end else begin
        fltCnt <= fltCnt + 1'b1;
      end
    end
  end

  assign lineHigh = filtQ;
  assign lineFell = filtPrevQ & ~filtQ;

  // R8/R9: counts captured on start, zero promoted to one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCfg  <= CNT_ONE;
      highCfg <= CNT_ONE;
    end else if (ctrl.latchCfg) begin
      lowCfg  <= (lowCount  == '0) ? CNT_ONE : lowCount;
      highCfg <= (highCount == '0) ? CNT_ONE : highCount;
    end
  end

  // period counter: zero means not running, one means expiring now
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              perCnt <= '0;
    else if (ctrl.clear)    perCnt <= '0;
    else if (ctrl.loadLow)  perCnt <= lowCfg;
    else if (ctrl.loadHigh) perCnt <= highCfg;
    else if (perCnt != '0)  perCnt <= perCnt - 1'b1;
  end

  assign cntDone = (perCnt == CNT_ONE);
  assign cntIdle = (perCnt == '0);
endmodule

// File: rtl/sclGenControl.sv
module sclGenControl
  import sclGenPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    stopReq,
  input  logic    lineHigh,
  input  logic    lineFell,
  input  logic    cntDone,
  input  logic    cntIdle,
  output sclCtrlT ctrl,
  output logic    sclDriveLow,
  output logic    sampleStb,
  output logic    changeStb
);
  sclStateT stateQ, stateNext;
  logic     smpNext, chgNext;

  always_comb begin
    stateNext = stateQ;
    ctrl      = '0;
    smpNext   = 1'b0;
    chgNext   = 1'b0;
    if (!enable || stopReq) begin
      stateNext  = ST_IDLE;          // R1, R10
      ctrl.clear = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          stateNext     = ST_LOW;    // R2
          ctrl.latchCfg = 1'b1;
          ctrl.clear    = 1'b1;
        end
        ST_LOW: begin
          // R7: (re)start the low count from the line's fall
          if (lineFell || (cntIdle && !lineHigh)) begin
            ctrl.loadLow = 1'b1;
            chgNext      = 1'b1;
          end else if (cntDone) begin
            stateNext = ST_HWAIT;
          end
        end
        ST_HWAIT: begin
          // R5: high time counts only once the line reads high
          if (lineHigh) begin
            stateNext     = ST_HIGH;
            ctrl.loadHigh = 1'b1;
            smpNext       = 1'b1;
          end
        end
        ST_HIGH: begin
          // R6: any fall ends the high phase
          if (lineFell) begin
            stateNext    = ST_LOW;
            ctrl.loadLow = 1'b1;
            chgNext      = 1'b1;
          end else if (cntDone) begin
            stateNext = ST_LOW;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      sampleStb <= 1'b0;
      changeStb <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      sampleStb <= smpNext;
      changeStb <= chgNext;
    end
  end

  assign sclDriveLow = (stateQ == ST_LOW);
endmodule

// File: rtl/sclGen.sv
module sclGen
  import sclGenPkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             stopReq,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sampleStb,
  output logic             changeStb
);
  sclCtrlT ctrl;
  logic    lineHigh, lineFell, cntDone, cntIdle;

  sclGenDatapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .GLITCH_CYCLES(GLITCH_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .lowCount(lowCount), .highCount(highCount), .sclIn(sclIn),
    .lineHigh(lineHigh), .lineFell(lineFell),
    .cntDone(cntDone), .cntIdle(cntIdle)
  );

  sclGenControl ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .stopReq(stopReq),
    .lineHigh(lineHigh), .lineFell(lineFell),
    .cntDone(cntDone), .cntIdle(cntIdle),
    .ctrl(ctrl), .sclDriveLow(sclDriveLow),
    .sampleStb(sampleStb), .changeStb(changeStb)
  );
endmodule

// File: rtl/sclGenChecker.sv
module sclGenChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic stopReq,
  input logic sclDriveLow,
  input logic sampleStb,
  input logic changeStb
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !sampleStb && !changeStb));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enable) && !stopReq) |=> sclDriveLow);

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !sclDriveLow);

  a_r11_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> !sclDriveLow);

  a_r11_change_driving: assert property (@(posedge clk) disable iff (!rstN)
    changeStb |-> sclDriveLow);

  a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && changeStb));

  a_r11_sample_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  a_r11_change_single: assert property (@(posedge clk) disable iff (!rstN)
    changeStb |=> !changeStb);
endmodule

bind sclGen sclGenChecker chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .stopReq(stopReq),
  .sclDriveLow(sclDriveLow), .sampleStb(sampleStb), .changeStb(changeStb)
);

// File: tb/sclGen_tb_top.sv
`timescale 1ns/1ps
module sclGen_tb_top;
  localparam int LAT = 2 + 3 + 1;

  typedef struct {
    bit    isLow;
    int    len;
    string req;
  } expT;

  logic        clk = 1'b0;
  logic        rstN, enable, stopReq;
  logic [15:0] lowCount, highCount;
  logic        dutLow, sampleStb, changeStb;
  logic        otherEn, otherPull, glitchPull;
  logic        line;
  int          oLowLen, oHighLen, lowRun, highRun;
  int          nChecks = 0, nFail = 0;
  expT         q[$];
  expT         e;
  bit          armed = 0, runArmed = 0;
  logic        prevLine = 1'b1;
  int          runLen = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  assign line = !(dutLow | otherPull | glitchPull);

  sclGen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .stopReq(stopReq),
    .lowCount(lowCount), .highCount(highCount), .sclIn(line),
    .sclDriveLow(dutLow), .sampleStb(sampleStb), .changeStb(changeStb)
  );

  // second clock source on the wired-AND line, reacting to the line directly
  always @(posedge clk) begin
    if (!line) begin lowRun <= lowRun + 1; highRun <= 0; end
    else       begin highRun <= highRun + 1; lowRun <= 0; end
    if (!otherEn)  otherPull <= 1'b0;
    else if (line) otherPull <= (highRun + 1 >= oHighLen);
    else           otherPull <= (lowRun + 1 < oLowLen);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures line phases and compares them with queued expectations
  always @(negedge clk) begin
    if (rstN) begin
      if (line == prevLine) runLen++;
      else begin
        if (runArmed && q.size() > 0) begin
          e = q.pop_front();
          chk(((prevLine == 1'b0) == e.isLow) && (runLen == e.len),
              e.req, runLen, e.len);
        end
        runLen   = 1;
        runArmed = armed;
        prevLine = line;
      end
    end
  end

  // driver: queues expected phase lengths and waits for the monitor to drain them
  task automatic measure(int expLow, int expHigh, int n, string req);
    armed = 0;
    do @(negedge clk); while (line);
    do @(negedge clk); while (!line);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      q.push_back('{1'b1, expLow, req});
      q.push_back('{1'b0, expHigh, req});
    end
    armed = 1;
    while (q.size() > 0) @(negedge clk);
    armed = 0;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int k;
    rstN = 0; enable = 0; stopReq = 0; lowCount = 16'd10; highCount = 16'd8;
    otherEn = 0; glitchPull = 0; oLowLen = 1; oHighLen = 1;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!dutLow && !sampleStb && !changeStb, "R1 reset quiet",
        int'({dutLow, sampleStb, changeStb}), 0);

    // R2: start
    enable = 1;
    @(negedge clk);
    chk(dutLow == 1'b1, "R2 drive low after enable", int'(dutLow), 1);

    // R3 R4: stand-alone periods
    measure(10 + LAT, 8 + LAT, 2, "R3 R4 stand-alone");

    // R11: strobe placement
    do @(negedge clk); while (dutLow);
    do @(negedge clk); while (!dutLow);
    k = 1;
    while (!changeStb && k < 100) begin @(negedge clk); k++; end
    chk(k == LAT + 1, "R11 changeStb position", k, LAT + 1);
    @(negedge clk);
    chk(!changeStb, "R11 changeStb one cycle", int'(changeStb), 0);
    do @(negedge clk); while (dutLow);
    k = 1;
    while (!sampleStb && k < 100) begin @(negedge clk); k++; end
    chk(k == LAT + 1, "R11 sampleStb position", k, LAT + 1);
    @(negedge clk);
    chk(!sampleStb, "R11 sampleStb one cycle", int'(sampleStb), 0);

    // R9: counts changed while running are ignored
    lowCount = 16'd50; highCount = 16'd50;
    measure(10 + LAT, 8 + LAT, 1, "R9 counts held");

    // R8: zero counts
    enable = 0;
    @(negedge clk);
    chk(!dutLow, "R1 disabled release", int'(dutLow), 0);
    lowCount = 16'd0; highCount = 16'd0;
    repeat (10) @(negedge clk);
    enable = 1;
    measure(1 + LAT, 1 + LAT, 2, "R8 zero as one");

    // R5 R6 R7: slower-low, faster-high partner dominates both phases
    enable = 0;
    lowCount = 16'd10; highCount = 16'd20;
    oLowLen = 30; oHighLen = 9; otherEn = 1;
    repeat (10) @(negedge clk);
    enable = 1;
    measure(30, 9, 3, "R5 R6 R7 partner dominates");

    // R6 R7: block's own longer low and shorter high dominate
    enable = 0; otherEn = 0;
    lowCount = 16'd20; highCount = 16'd5;
    oLowLen = 12; oHighLen = 40;
    repeat (10) @(negedge clk);
    otherEn = 1; enable = 1;
    measure(20 + LAT, 5 + LAT, 2, "R6 R7 block dominates");

    // R12: short glitch during the high count
    enable = 0; otherEn = 0;
    lowCount = 16'd10; highCount = 16'd30;
    repeat (10) @(negedge clk);
    enable = 1;
    repeat (3) begin
      do @(negedge clk); while (!dutLow);
      do @(negedge clk); while (dutLow);
    end
    k = 1;
    while (!dutLow && k < 200) begin
      @(negedge clk); k++;
      if (k == 15) glitchPull = 1;
      if (k == 17) glitchPull = 0;
    end
    chk(k == 30 + LAT + 1, "R12 glitch ignored", k, 30 + LAT + 1);

    // R10: stop and restart
    do @(negedge clk); while (!dutLow);
    stopReq = 1;
    @(negedge clk);
    chk(!dutLow, "R10 stop releases", int'(dutLow), 0);
    repeat (20) @(negedge clk);
    chk(!dutLow && !sampleStb && !changeStb, "R10 stays idle",
        int'({dutLow, sampleStb, changeStb}), 0);
    stopReq = 0;
    @(negedge clk);
    chk(dutLow == 1'b1, "R10 restart low", int'(dutLow), 1);
    measure(10 + LAT, 30 + LAT, 1, "R10 periods after restart");

    enable = 0;
    @(negedge clk);
    chk(!dutLow && !sampleStb && !changeStb, "R1 final disable",
        int'({dutLow, sampleStb, changeStb}), 0);
    report();
  end
endmodule